// File: doc/BRIEF.md
# Interleaved Half-Duplex Converter Bus Adapter

This block sits on the host side of a dual-channel data converter that is reached through a single 12-bit bidirectional word bus. Only one direction is active at a time. In transmit, the block takes two channel streams, A and B, and sends them as alternating words on the bus. The most significant bit of an otherwise idle neighbour bus serves as a sync line that tags each word with its channel. A word clock output rises once in the middle of each word. In receive, the converter drives interleaved words and a channel indicator. The block sorts each word into a channel A or a channel B output register. Each of those registers has a valid/ready handshake.

A direction input selects transmit or receive. The block drives the word bus and the sync line only while transmitting. When the direction changes, the pad drivers stay released for one clock cycle before the new direction takes effect. Each transmitted word occupies two clock cycles: the word and its sync level change on the first cycle, and the word clock is high on the second.

Top module: `cvbus_adapter`

## Requirements
- R1: While reset is high and on the first cycle after it, `bus_oe`, `sync_oe`, `word_clk`, `tx_underrun`, both receive valids, `rx_overrun` and `rx_frame_err` are all 0, and the block is in receive.
- R2: `bus_oe` and `sync_oe` are high only in transmit. After `dir_tx` rises, they go high on the second clock edge, not the first. After `dir_tx` falls, they go low on the next edge.
- R3: Each transmit burst starts with channel A, and the channels then alternate A, B, A, B. `sync_out` is 1 on a channel A word and 0 on a channel B word.
- R4: `word_clk` is 0 on the cycle in which a new word first appears on `bus_out`. It is 1 on the following cycle, and `bus_out` stays unchanged across that rising edge. Each word spans two cycles.
- R5: `tx_a_ready` and `tx_b_ready` are never high together. Each is high only on the cycle in which its channel's word is due. When channel A has no valid data in its slot, no word is sent: `bus_out` holds and `word_clk` stays 0 until A becomes valid.
- R6: When channel B is due and `tx_b_valid` is 0, the last B word sent is repeated on the bus, and `tx_underrun` pulses for one cycle.
- R7: In receive, a word is captured on a clock edge where `rx_word_stb` is 1. With `sync_in` at 0 the word goes to channel A; with `sync_in` at 1 it goes to channel B. The data and valid appear on the cycle after that edge.
- R8: A channel B word that arrives without a channel A word since the last B word, or since entering receive, sets `rx_frame_err`. The bit then stays set until reset, and the stray word is still delivered on channel B.
- R9: A channel output keeps its valid and data unchanged until its ready is seen high on a clock edge. On that edge valid clears, unless a new word for that channel loads on the same edge.
- R10: If a word arrives for a channel whose output is valid and not being read, the held word is kept and the new one is dropped. The matching bit of `rx_overrun` pulses for one cycle, where bit 0 is channel A and bit 1 is channel B.
- R11: Strobed receive words are ignored in transmit and during both turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 1 selects transmit, 0 selects receive |
| tx_a_data | input | 12 | Channel A transmit sample |
| tx_a_valid | input | 1 | Channel A sample present |
| tx_a_ready | output | 1 | Channel A sample taken on this edge |
| tx_b_data | input | 12 | Channel B transmit sample |
| tx_b_valid | input | 1 | Channel B sample present |
| tx_b_ready | output | 1 | Channel B slot due on this edge |
| tx_underrun | output | 1 | One-cycle pulse on a repeated B word |
| rx_a_data | output | 12 | Channel A received sample |
| rx_a_valid | output | 1 | Channel A output holds a sample |
| rx_a_ready | input | 1 | Consumer takes channel A sample |
| rx_b_data | output | 12 | Channel B received sample |
| rx_b_valid | output | 1 | Channel B output holds a sample |
| rx_b_ready | input | 1 | Consumer takes channel B sample |
| rx_overrun | output | 2 | One-cycle drop pulse, bit 0 channel A, bit 1 channel B |
| rx_frame_err | output | 1 | Sticky stray-B framing error |
| bus_in | input | 12 | Word bus pad input |
| bus_out | output | 12 | Word bus pad output |
| bus_oe | output | 1 | Word bus pad driver enable |
| sync_in | input | 1 | Receive channel indicator pad input |
| sync_out | output | 1 | Transmit sync pad output |
| sync_oe | output | 1 | Sync pad driver enable |
| word_clk | output | 1 | Word latch clock, one rising edge per word |
| rx_word_stb | input | 1 | Receive word present on the bus |

## Verification
The bench measures the turnaround gap in both directions. A design that enables its drivers on the first edge after `dir_tx` rises would contend with the converter. It also strobes a receive word during the turnaround cycle and during transmit. A design that captures it would deliver a word the converter never meant for the host. In transmit, the bench withdraws channel B to catch a design that sends stale or zero data in place of the previous B word, or that leaves the underrun pulse silent. It then withdraws channel A to catch a design that sends B first or clocks out an empty slot. In receive, it checks that a stray B word sets the error, that the word is still delivered, and that the error bit stays set through a later direction change. It also stalls one consumer so that a design which overwrites its held word on overrun is caught.

// File: rtl/cvb_pkg.sv
package cvb_pkg;

    parameter int unsigned WORD_W = 12;
    parameter int unsigned N_CHAN = 2;

    typedef enum logic [1:0] {
        MD_RX      = 2'd0,
        MD_TURN_TX = 2'd1,
        MD_TX      = 2'd2,
        MD_TURN_RX = 2'd3
    } mode_e;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // transmit sync level: high tags channel A
    function automatic logic tx_sync_level(chan_e c);
        return (c == CH_A);
    endfunction

    // receive indicator: low tags channel A
    function automatic chan_e rx_chan_of(logic ind);
        return ind ? CH_B : CH_A;
    endfunction

    function automatic chan_e other_chan(chan_e c);
        return (c == CH_A) ? CH_B : CH_A;
    endfunction

endpackage

// File: rtl/cvb_dir_ctrl.sv
module cvb_dir_ctrl
    import cvb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  dir_tx,
    output mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MD_RX;
        end else begin
            case (mode)
                MD_RX:      if (dir_tx) mode <= MD_TURN_TX;
                MD_TURN_TX: mode <= dir_tx ? MD_TX : MD_RX;
                MD_TX:      if (!dir_tx) mode <= MD_TURN_RX;
                MD_TURN_RX: mode <= dir_tx ? MD_TURN_TX : MD_RX;
                default:    mode <= MD_RX;
            endcase
        end
    end

endmodule

// File: rtl/cvb_tx_mux.sv
module cvb_tx_mux
    import cvb_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [DW-1:0] a_data,
    input  logic          a_valid,
    output logic          a_ready,
    input  logic [DW-1:0] b_data,
    input  logic          b_valid,
    output logic          b_ready,
    output logic [DW-1:0] word_o,
    output logic          sync_o,
    output logic          lclk_o,
    output logic          underrun_o
);

    chan_e         slot;
    logic          half;
    logic [DW-1:0] word_q;
    logic [DW-1:0] b_last;
    logic          sync_q;
    logic          lclk_q;
    logic          undr_q;
    logic          load;

    assign a_ready = active && !half && (slot == CH_A);
    assign b_ready = active && !half && (slot == CH_B);
    assign load    = (a_ready && a_valid) || b_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= CH_A;
            half   <= 1'b0;
            word_q <= '0;
            b_last <= '0;
            sync_q <= 1'b0;
            lclk_q <= 1'b0;
            undr_q <= 1'b0;
        end else begin
            undr_q <= 1'b0;
            if (!active) begin
                slot   <= CH_A;
                half   <= 1'b0;
                lclk_q <= 1'b0;
            end else if (half) begin
                lclk_q <= 1'b1;
                half   <= 1'b0;
                slot   <= other_chan(slot);
            end else begin
                lclk_q <= 1'b0;
                if (load) begin
                    half   <= 1'b1;
                    sync_q <= tx_sync_level(slot);
                    if (slot == CH_A) begin
                        word_q <= a_data;
                    end else if (b_valid) begin
                        word_q <= b_data;
                        b_last <= b_data;
                    end else begin
                        word_q <= b_last;
                        undr_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign word_o     = word_q;
    assign sync_o     = sync_q;
    assign lclk_o     = lclk_q;
    assign underrun_o = undr_q;

endmodule

// File: rtl/cvb_chan_reg.sv
module cvb_chan_reg #(
    parameter int unsigned DW = cvb_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          rdy,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic          ovr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            ovr <= 1'b0;
            if (load) begin
                if (valid && !rdy) begin
                    ovr <= 1'b1;
                end else begin
                    dout  <= din;
                    valid <= 1'b1;
                end
            end else if (rdy) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cvb_rx_demux.sv
module cvb_rx_demux
    import cvb_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned NC = N_CHAN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  active,
    input  logic                  stb,
    input  logic [DW-1:0]         word_in,
    input  logic                  ind_in,
    input  logic [NC-1:0]         rdy,
    output logic [NC-1:0][DW-1:0] data,
    output logic [NC-1:0]         valid,
    output logic [NC-1:0]         ovr,
    output logic                  frm_err
);

    chan_e ch;
    logic  cap;
    logic  a_seen;
    logic  frm_q;

    assign ch  = rx_chan_of(ind_in);
    assign cap = active && stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_seen <= 1'b0;
            frm_q  <= 1'b0;
        end else if (!active) begin
            a_seen <= 1'b0;
        end else if (cap) begin
            if (ch == CH_A) begin
                a_seen <= 1'b1;
            end else begin
                if (!a_seen) frm_q <= 1'b1;
                a_seen <= 1'b0;
            end
        end
    end

    assign frm_err = frm_q;

    for (genvar g = 0; g < NC; g++) begin : g_chan
        cvb_chan_reg #(.DW(DW)) reg_i (
            .clk   (clk),
            .rst   (rst),
            .load  (cap && (int'(ch) == g)),
            .din   (word_in),
            .rdy   (rdy[g]),
            .dout  (data[g]),
            .valid (valid[g]),
            .ovr   (ovr[g])
        );
    end

endmodule

// File: rtl/cvbus_adapter.sv
module cvbus_adapter
    import cvb_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_tx,
    input  logic [DW-1:0] tx_a_data,
    input  logic          tx_a_valid,
    output logic          tx_a_ready,
    input  logic [DW-1:0] tx_b_data,
    input  logic          tx_b_valid,
    output logic          tx_b_ready,
    output logic          tx_underrun,
    output logic [DW-1:0] rx_a_data,
    output logic          rx_a_valid,
    input  logic          rx_a_ready,
    output logic [DW-1:0] rx_b_data,
    output logic          rx_b_valid,
    input  logic          rx_b_ready,
    output logic [1:0]    rx_overrun,
    output logic          rx_frame_err,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          sync_in,
    output logic          sync_out,
    output logic          sync_oe,
    output logic          word_clk,
    input  logic          rx_word_stb
);

    mode_e                mode;
    logic [1:0][DW-1:0]   rx_data;
    logic [1:0]           rx_valid;

    cvb_dir_ctrl dir_i (
        .clk    (clk),
        .rst    (rst),
        .dir_tx (dir_tx),
        .mode   (mode)
    );

    cvb_tx_mux #(.DW(DW)) tx_i (
        .clk        (clk),
        .rst        (rst),
        .active     (mode == MD_TX),
        .a_data     (tx_a_data),
        .a_valid    (tx_a_valid),
        .a_ready    (tx_a_ready),
        .b_data     (tx_b_data),
        .b_valid    (tx_b_valid),
        .b_ready    (tx_b_ready),
        .word_o     (bus_out),
        .sync_o     (sync_out),
        .lclk_o     (word_clk),
        .underrun_o (tx_underrun)
    );

    cvb_rx_demux #(.DW(DW), .NC(2)) rx_i (
        .clk     (clk),
        .rst     (rst),
        .active  (mode == MD_RX),
        .stb     (rx_word_stb),
        .word_in (bus_in),
        .ind_in  (sync_in),
        .rdy     ({rx_b_ready, rx_a_ready}),
        .data    (rx_data),
        .valid   (rx_valid),
        .ovr     (rx_overrun),
        .frm_err (rx_frame_err)
    );

    assign bus_oe     = (mode == MD_TX);
    assign sync_oe    = (mode == MD_TX);
    assign rx_a_data  = rx_data[0];
    assign rx_b_data  = rx_data[1];
    assign rx_a_valid = rx_valid[0];
    assign rx_b_valid = rx_valid[1];

endmodule

// File: rtl/cvbus_adapter_chk.sv
module cvbus_adapter_chk #(
    parameter int unsigned DW = cvb_pkg::WORD_W
) (
    input logic          clk,
    input logic          rst,
    input logic          dir_tx,
    input logic [DW-1:0] tx_a_data,
    input logic          tx_a_valid,
    input logic          tx_a_ready,
    input logic          tx_b_valid,
    input logic          tx_b_ready,
    input logic          tx_underrun,
    input logic [DW-1:0] rx_a_data,
    input logic          rx_a_valid,
    input logic          rx_a_ready,
    input logic [DW-1:0] rx_b_data,
    input logic          rx_b_valid,
    input logic          rx_b_ready,
    input logic          rx_frame_err,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe,
    input logic          sync_out,
    input logic          word_clk
);

    assert_oe_needs_dir_R2: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> $past(dir_tx));

    assert_turnaround_gap_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(dir_tx, 2));

    assert_a_word_tag_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_a_ready && tx_a_valid) |=> (sync_out && bus_out == $past(tx_a_data)));

    assert_b_word_tag_R3: assert property (@(posedge clk) disable iff (rst)
        tx_b_ready |=> !sync_out);

    assert_wclk_single_R4: assert property (@(posedge clk) disable iff (rst)
        word_clk |=> !word_clk);

    assert_wclk_mid_word_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(word_clk) |-> $stable(bus_out));

    assert_ready_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(tx_a_ready && tx_b_ready));

    assert_underrun_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_b_ready && !tx_b_valid) |=> tx_underrun);

    assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        rx_frame_err |=> rx_frame_err);

    assert_hold_a_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_a_valid && !rx_a_ready) |=> (rx_a_valid && $stable(rx_a_data)));

    assert_hold_b_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_b_valid && !rx_b_ready) |=> (rx_b_valid && $stable(rx_b_data)));

endmodule

bind cvbus_adapter cvbus_adapter_chk #(.DW(DW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .dir_tx       (dir_tx),
    .tx_a_data    (tx_a_data),
    .tx_a_valid   (tx_a_valid),
    .tx_a_ready   (tx_a_ready),
    .tx_b_valid   (tx_b_valid),
    .tx_b_ready   (tx_b_ready),
    .tx_underrun  (tx_underrun),
    .rx_a_data    (rx_a_data),
    .rx_a_valid   (rx_a_valid),
    .rx_a_ready   (rx_a_ready),
    .rx_b_data    (rx_b_data),
    .rx_b_valid   (rx_b_valid),
    .rx_b_ready   (rx_b_ready),
    .rx_frame_err (rx_frame_err),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .sync_out     (sync_out),
    .word_clk     (word_clk)
);

// File: tb/cvbus_adapter_tb_top.sv
module cvbus_adapter_tb_top;

    localparam int DW = 12;

    // receive table: bit 13 channel indicator, bit 12 expected frame error, 11:0 word
    localparam logic [13:0] RXV [0:5] = '{
        14'h0123, 14'h2456, 14'h0ABC, 14'h2FFF, 14'h3001, 14'h1800
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dir_tx = 1'b0;
    logic [DW-1:0] tx_a_data = '0;
    logic          tx_a_valid = 1'b0;
    logic          tx_a_ready;
    logic [DW-1:0] tx_b_data = '0;
    logic          tx_b_valid = 1'b0;
    logic          tx_b_ready;
    logic          tx_underrun;
    logic [DW-1:0] rx_a_data;
    logic          rx_a_valid;
    logic          rx_a_ready = 1'b1;
    logic [DW-1:0] rx_b_data;
    logic          rx_b_valid;
    logic          rx_b_ready = 1'b1;
    logic [1:0]    rx_overrun;
    logic          rx_frame_err;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic          sync_in = 1'b0;
    logic          sync_out;
    logic          sync_oe;
    logic          word_clk;
    logic          rx_word_stb = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cvbus_adapter #(.DW(DW)) dut_i (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_word(input logic ind, input logic [DW-1:0] w);
        sync_in     = ind;
        bus_in      = w;
        rx_word_stb = 1'b1;
        tick();
        rx_word_stb = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        chk(bus_oe == 0 && sync_oe == 0 && word_clk == 0, "R1 drivers", int'(bus_oe), 0);
        chk(rx_a_valid == 0 && rx_b_valid == 0 && rx_frame_err == 0, "R1 rx state",
            int'({rx_a_valid, rx_b_valid, rx_frame_err}), 0);
        rst = 1'b0;
        tick();
        chk(bus_oe == 0 && rx_overrun == 0 && tx_underrun == 0, "R1 after release",
            int'({bus_oe, rx_overrun, tx_underrun}), 0);

        // R7 R8: table walk, consumers always ready
        for (int i = 0; i < 6; i++) begin
            rx_word(RXV[i][13], RXV[i][11:0]);
            if (RXV[i][13] == 1'b0) begin
                chk(rx_a_valid && rx_a_data == RXV[i][11:0] && !rx_b_valid, "R7 chan A",
                    int'(rx_a_data), int'(RXV[i][11:0]));
            end else begin
                chk(rx_b_valid && rx_b_data == RXV[i][11:0] && !rx_a_valid, "R7 chan B / R8 stray delivered",
                    int'(rx_b_data), int'(RXV[i][11:0]));
            end
            chk(rx_frame_err == RXV[i][12], "R8 frame error", int'(rx_frame_err), int'(RXV[i][12]));
        end
        tick();

        // R9 R10: stalled channel A consumer
        rx_a_ready = 1'b0;
        rx_word(1'b0, 12'h111);
        rx_word(1'b0, 12'h222);
        chk(rx_overrun == 2'b01, "R10 overrun pulse", int'(rx_overrun), 1);
        chk(rx_a_valid && rx_a_data == 12'h111, "R10 held word kept", int'(rx_a_data), 'h111);
        tick();
        chk(rx_overrun == 2'b00, "R10 pulse one cycle", int'(rx_overrun), 0);
        chk(rx_a_valid && rx_a_data == 12'h111, "R9 hold until ready", int'(rx_a_data), 'h111);
        rx_a_ready = 1'b1;
        tick();
        chk(rx_a_valid == 0, "R9 ready clears", int'(rx_a_valid), 0);

        // transmit
        tx_a_data = 12'h5A5; tx_a_valid = 1'b1;
        tx_b_data = 12'h3C3; tx_b_valid = 1'b1;
        dir_tx = 1'b1;
        tick();
        chk(bus_oe == 0 && sync_oe == 0, "R2 turnaround gap", int'(bus_oe), 0);
        tick();
        chk(bus_oe == 1 && sync_oe == 1, "R2 drive in tx", int'(bus_oe), 1);
        chk(tx_a_ready == 1 && tx_b_ready == 0, "R5 A slot first", int'({tx_a_ready, tx_b_ready}), 2);
        tick();
        chk(bus_out == 12'h5A5 && sync_out == 1 && word_clk == 0, "R3 A word sync high",
            int'({sync_out, bus_out}), 'h15A5);
        tick();
        chk(word_clk == 1 && bus_out == 12'h5A5, "R4 word clock mid word", int'(word_clk), 1);
        tick();
        chk(bus_out == 12'h3C3 && sync_out == 0 && word_clk == 0 && tx_underrun == 0, "R3 B word sync low",
            int'({sync_out, bus_out}), 'h03C3);
        tx_b_valid = 1'b0;
        tx_a_data  = 12'h0F0;
        tick();
        chk(word_clk == 1, "R4 second word clock", int'(word_clk), 1);
        tick();
        chk(bus_out == 12'h0F0 && sync_out == 1, "R3 alternation back to A", int'(bus_out), 'h0F0);
        tick();
        tick();
        chk(bus_out == 12'h3C3 && sync_out == 0 && tx_underrun == 1, "R6 repeat last B",
            int'({tx_underrun, bus_out}), 'h13C3);
        tx_a_valid = 1'b0;
        tick();
        chk(tx_underrun == 0, "R6 underrun one cycle", int'(tx_underrun), 0);
        tick();
        sync_in = 1'b0; bus_in = 12'h999; rx_word_stb = 1'b1;
        tick();
        rx_word_stb = 1'b0;
        chk(word_clk == 0 && bus_out == 12'h3C3, "R5 no word without A", int'(word_clk), 0);
        chk(rx_a_valid == 0, "R11 ignored in tx", int'(rx_a_valid), 0);

        // back to receive
        dir_tx = 1'b0;
        tick();
        chk(bus_oe == 0 && sync_oe == 0, "R2 release on exit", int'(bus_oe), 0);
        rx_word(1'b0, 12'h777);
        chk(rx_a_valid == 0, "R11 ignored in turnaround", int'(rx_a_valid), 0);
        rx_word(1'b0, 12'h778);
        chk(rx_a_valid && rx_a_data == 12'h778, "R7 capture after turnaround", int'(rx_a_data), 'h778);
        chk(rx_frame_err == 1, "R8 error stays set", int'(rx_frame_err), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule